// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating Controller

This block decides, cycle by cycle, which peripheral clocks are allowed to run. Software programs three complete enable sets (run, sleep, deep sleep) for each of two bus groups: a high-speed group of 13 enable lanes and a peripheral group of 18 lanes. A 2-bit power-mode input selects which of the three sets drives the registered per-peripheral gate-enable outputs. The outputs are level enables for external clock-gating cells. The block contains no gating cells of its own.

A separate watchdog function-clock enable is also produced. A control bit lets software stop that clock while the chip is in deep sleep. When the mode leaves deep sleep, the enable returns to 1 on the next clock edge with no software action. The control bit keeps its value, so the next deep-sleep entry stops the clock again.

Software reaches the registers through a simple write/read port. Writes are captured on a clock edge, and reads return the current contents combinationally.

Top module: `pm_clkgate_ctrl`

## Requirements
- R1: The six enable registers decode at byte addresses 0x28 (high-speed run), 0x2C (peripheral run), 0x30 (high-speed sleep), 0x34 (peripheral sleep), 0x38 (high-speed deep sleep) and 0x3C (peripheral deep sleep). A write stores the data bits of the group width, and a read returns the stored value.
- R2: After reset, every usable enable bit in all six registers reads 1, and the watchdog control bit reads 0. The gate outputs equal the run sets, and the watchdog enable is 1.
- R3: Power-mode encoding is 0 = run, 1 = sleep, 2 = deep sleep; code 3 behaves as run. The gate outputs carry the two registers of the selected mode.
- R4: Reserved lanes are bits 2, 3 and 8 of the high-speed group and bits 5, 7, 13, 14 and 15 of the peripheral group. They always read 0, writes to them are dropped, and the matching outputs stay 0.
- R5: A mode change or register write sampled on clock edge k is visible on the outputs right after edge k, and not before it.
- R6: Bit 18 of the control register at address 0x00 stops the watchdog function clock (enable 0) only while the mode is deep sleep. Every other bit of that register reads 0.
- R7: When the mode leaves deep sleep, the watchdog enable returns to 1 after the next edge without any write. The control bit keeps its value.
- R8: Writes to any other address change no register and no output, and reads there return 0.
- R9: With the write strobe low, no register changes, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| pm_mode | input | 2 | CPU power mode: 0 run, 1 sleep, 2 deep sleep, 3 as run |
| hs_clk_en | output | 13 | High-speed group gate enables |
| pb_clk_en | output | 18 | Peripheral group gate enables |
| wdt_fclk_en | output | 1 | Watchdog function clock enable |

## Verification
Every gate output and the watchdog enable is due exactly one edge after the write or mode value that causes it. The bench drives inputs on the falling edge. It checks outputs on the falling edge that follows the capturing rising edge. For mode changes it also samples just before that rising edge, to confirm the old value still holds. Read data is combinational, so the bench checks it shortly after it sets the address, with the strobe low.

// File: rtl/pmcg_pkg.sv
package pmcg_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2,
    PM_ALT   = 2'd3
  } pm_mode_e;

  localparam int NMODES = 3;

  // mode code -> enable-set index; the spare code falls back to run
  function automatic logic [1:0] set_index(input logic [1:0] mode);
    return (mode == PM_ALT) ? 2'd0 : mode;
  endfunction

  // usable-lane mask from group width and reserved-lane vector
  function automatic logic [31:0] keep_mask(input int width, input logic [31:0] rsv);
    logic [31:0] full;
    full = (width >= 32) ? '1 : ((32'd1 << width) - 32'd1);
    return full & ~rsv;
  endfunction

  // byte address of enable register for a mode and a group (0 hs, 1 pb)
  function automatic int set_addr(input int base, input int mode, input int grp);
    return base + 8 * mode + 4 * grp;
  endfunction

endpackage

// File: rtl/pmcg_regbank.sv
module pmcg_regbank
  import pmcg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int HS_W     = 13,
  parameter int PB_W     = 18,
  parameter logic [HS_W-1:0] HS_KEEP = '1,
  parameter logic [PB_W-1:0] PB_KEEP = '1,
  parameter int CTL_ADDR = 'h00,
  parameter int SET_BASE = 'h28,
  parameter int WDT_BIT  = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NMODES-1:0][HS_W-1:0]   hs_d,
  output logic [NMODES-1:0][PB_W-1:0]   pb_d,
  output logic                          wdt_off_d
);

  logic [NMODES-1:0][HS_W-1:0] hs_q;
  logic [NMODES-1:0][PB_W-1:0] pb_q;
  logic [NMODES-1:0]           hit_hs, hit_pb;
  logic                        hit_ctl;
  logic                        wdt_off_q;

  assign hit_ctl   = we && (addr == ADDR_W'(CTL_ADDR));
  assign wdt_off_d = hit_ctl ? wdata[WDT_BIT] : wdt_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_off_q <= 1'b0;
    else        wdt_off_q <= wdt_off_d;
  end

  for (genvar m = 0; m < NMODES; m++) begin : g_set
    localparam logic [ADDR_W-1:0] A_HS = ADDR_W'(set_addr(SET_BASE, m, 0));
    localparam logic [ADDR_W-1:0] A_PB = ADDR_W'(set_addr(SET_BASE, m, 1));

    assign hit_hs[m] = we && (addr == A_HS);
    assign hit_pb[m] = we && (addr == A_PB);
    assign hs_d[m]   = hit_hs[m] ? (wdata[HS_W-1:0] & HS_KEEP) : hs_q[m];
    assign pb_d[m]   = hit_pb[m] ? (wdata[PB_W-1:0] & PB_KEEP) : pb_q[m];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_q[m] <= HS_KEEP;
        pb_q[m] <= PB_KEEP;
      end else begin
        hs_q[m] <= hs_d[m];
        pb_q[m] <= pb_d[m];
      end
    end

    // R1 / R4: a write lands masked on the next edge
    p_hs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hs[m] |=> (hs_q[m] == $past(wdata[HS_W-1:0] & HS_KEEP)));
    p_pb_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pb[m] |=> (pb_q[m] == $past(wdata[PB_W-1:0] & PB_KEEP)));
    // R8 / R9: no hit, no change
    p_hs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_hs[m] |=> $stable(hs_q[m]));
    p_pb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_pb[m] |=> $stable(pb_q[m]));
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTL_ADDR)) rdata[WDT_BIT] = wdt_off_q;
    for (int m = 0; m < NMODES; m++) begin
      if (addr == ADDR_W'(set_addr(SET_BASE, m, 0))) rdata[HS_W-1:0] = hs_q[m];
      if (addr == ADDR_W'(set_addr(SET_BASE, m, 1))) rdata[PB_W-1:0] = pb_q[m];
    end
  end

  // R6: control register holds its bit unless written
  p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ctl |=> $stable(wdt_off_q));

endmodule

// File: rtl/pmcg_mode_sel.sv
module pmcg_mode_sel
  import pmcg_pkg::*;
#(
  parameter int HS_W = 13,
  parameter int PB_W = 18,
  parameter logic [HS_W-1:0] HS_KEEP = '1,
  parameter logic [PB_W-1:0] PB_KEEP = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode,
  input  logic [NMODES-1:0][HS_W-1:0] hs_d,
  input  logic [NMODES-1:0][PB_W-1:0] pb_d,
  input  logic                        wdt_off_d,
  output logic [HS_W-1:0]             hs_en,
  output logic [PB_W-1:0]             pb_en,
  output logic                        wdt_en
);

  logic [1:0]      sel_idx;
  logic            in_deep;
  logic [HS_W-1:0] hs_pick;
  logic [PB_W-1:0] pb_pick;
  logic            wdt_pick;
  logic            live;

  assign sel_idx  = set_index(mode);
  assign in_deep  = (sel_idx == 2'd2);
  assign wdt_pick = !(in_deep && wdt_off_d);

  always_comb begin
    case (sel_idx)
      2'd1:    begin hs_pick = hs_d[1]; pb_pick = pb_d[1]; end
      2'd2:    begin hs_pick = hs_d[2]; pb_pick = pb_d[2]; end
      default: begin hs_pick = hs_d[0]; pb_pick = pb_d[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en  <= HS_KEEP;
      pb_en  <= PB_KEEP;
      wdt_en <= 1'b1;
      live   <= 1'b0;
    end else begin
      hs_en  <= hs_pick;
      pb_en  <= pb_pick;
      wdt_en <= wdt_pick;
      live   <= 1'b1;
    end
  end

  // R3: sleep code steers the sleep registers to the outputs
  p_sleep_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode) == PM_SLEEP) |->
      (hs_en == $past(hs_d[1]) && pb_en == $past(pb_d[1])));
  // R3: spare code behaves as run
  p_alt_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode) == PM_ALT) |->
      (hs_en == $past(hs_d[0]) && pb_en == $past(pb_d[0])));
  // R4: reserved lanes never enabled
  p_rsv_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_en & ~HS_KEEP) == '0) && ((pb_en & ~PB_KEEP) == '0));
  // R6: deep sleep with the stop bit set closes the watchdog clock
  p_wdt_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode) == PM_DEEP && $past(wdt_off_d)) |-> !wdt_en);
  // R7: outside deep sleep the watchdog clock is always open
  p_wdt_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode) != PM_DEEP) |-> wdt_en);

endmodule

// File: rtl/pm_clkgate_ctrl.sv
module pm_clkgate_ctrl
  import pmcg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int HS_W     = 13,
  parameter int PB_W     = 18,
  parameter logic [31:0] HS_RSV = 32'h0000_010C,
  parameter logic [31:0] PB_RSV = 32'h0000_E0A0,
  parameter int CTL_ADDR = 'h00,
  parameter int SET_BASE = 'h28,
  parameter int WDT_BIT  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        pm_mode,
  output logic [HS_W-1:0]   hs_clk_en,
  output logic [PB_W-1:0]   pb_clk_en,
  output logic              wdt_fclk_en
);

  localparam logic [HS_W-1:0] HS_KEEP = HS_W'(keep_mask(HS_W, HS_RSV));
  localparam logic [PB_W-1:0] PB_KEEP = PB_W'(keep_mask(PB_W, PB_RSV));

  logic [NMODES-1:0][HS_W-1:0] hs_next;
  logic [NMODES-1:0][PB_W-1:0] pb_next;
  logic                        wdt_off_next;

  pmcg_regbank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HS_W(HS_W), .PB_W(PB_W),
    .HS_KEEP(HS_KEEP), .PB_KEEP(PB_KEEP),
    .CTL_ADDR(CTL_ADDR), .SET_BASE(SET_BASE), .WDT_BIT(WDT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .hs_d(hs_next), .pb_d(pb_next), .wdt_off_d(wdt_off_next)
  );

  pmcg_mode_sel #(
    .HS_W(HS_W), .PB_W(PB_W), .HS_KEEP(HS_KEEP), .PB_KEEP(PB_KEEP)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(pm_mode),
    .hs_d(hs_next), .pb_d(pb_next), .wdt_off_d(wdt_off_next),
    .hs_en(hs_clk_en), .pb_en(pb_clk_en), .wdt_en(wdt_fclk_en)
  );

endmodule

// File: tb/pm_clkgate_ctrl_tb_top.sv
module pm_clkgate_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pm_mode = 2'd0;
  logic [12:0] hs_clk_en;
  logic [17:0] pb_clk_en;
  logic        wdt_fclk_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mreg [6];
  logic        mctl;
  logic [31:0] hs_ok, pb_ok;

  always #4 clk = ~clk;

  pm_clkgate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pm_mode(pm_mode),
    .hs_clk_en(hs_clk_en), .pb_clk_en(pb_clk_en), .wdt_fclk_en(wdt_fclk_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input int i);
    return (i % 2) ? pb_ok : hs_ok;
  endfunction

  function automatic logic [31:0] exp_hs(input logic [1:0] m);
    int k = (m == 2'd3) ? 0 : int'(m);
    return mreg[2*k];
  endfunction

  function automatic logic [31:0] exp_pb(input logic [1:0] m);
    int k = (m == 2'd3) ? 0 : int'(m);
    return mreg[2*k+1];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    for (int i = 0; i < 6; i++)
      if (a == 8'(8'h28 + 4*i)) mreg[i] = d & keep_of(i);
    if (a == 8'h00) mctl = d[18];
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic chk_out(input string req);
    chk({req, " hs"}, 32'(hs_clk_en), exp_hs(pm_mode));
    chk({req, " pb"}, 32'(pb_clk_en), exp_pb(pm_mode));
    chk({req, " wdt"}, 32'(wdt_fclk_en), 32'(!(pm_mode == 2'd2 && mctl)));
  endtask

  task automatic rd_all(input string req);
    for (int i = 0; i < 6; i++) rd(req, 8'(8'h28 + 4*i), mreg[i]);
    rd(req, 8'h00, {13'b0, mctl, 18'b0});
  endtask

  task automatic set_mode(input logic [1:0] m);
    logic [31:0] ohs, opb;
    @(negedge clk);
    ohs = 32'(hs_clk_en); opb = 32'(pb_clk_en);
    pm_mode = m;
    #1;
    chk("R5 before edge hs", 32'(hs_clk_en), ohs);
    chk("R5 before edge pb", 32'(pb_clk_en), opb);
    @(negedge clk);
    chk_out("R3 after edge");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    int hr [3];
    int pr [5];
    hr = '{2, 3, 8};
    pr = '{5, 7, 13, 14, 15};
    pats = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1234_5678};
    hs_ok = (32'd1 << 13) - 1;
    pb_ok = (32'd1 << 18) - 1;
    foreach (hr[j]) hs_ok[hr[j]] = 1'b0;
    foreach (pr[j]) pb_ok[pr[j]] = 1'b0;
    for (int i = 0; i < 6; i++) mreg[i] = keep_of(i);
    mctl = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset contents and outputs
    chk_out("R2 reset");
    rd_all("R2 reset read");

    // R1, R4, R5: sweep every register with several patterns
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 6; i++) begin
        wr(8'(8'h28 + 4*i), pats[p] ^ (32'h0101_1111 * 32'(i)));
        chk_out("R5 write to output R1");
        rd("R1 R4 readback", 8'(8'h28 + 4*i), mreg[i]);
      end
    end

    // distinct values per set, then R3 over every mode code
    for (int i = 0; i < 6; i++) wr(8'(8'h28 + 4*i), 32'h0003_1C21 << i);
    rd_all("R1 distinct sets");
    for (int m = 0; m < 4; m++) set_mode(2'(m));
    for (int m = 3; m >= 0; m--) set_mode(2'(m));

    // R4: all-ones in deep sleep keeps reserved lanes low
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    set_mode(2'd2);
    chk("R4 hs reserved out", 32'(hs_clk_en) & ~hs_ok, 32'h0);
    chk("R4 pb reserved out", 32'(pb_clk_en) & ~pb_ok, 32'h0);

    // R8: unmapped addresses
    set_mode(2'd0);
    wr(8'h04, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h2A, 32'h0);
    chk_out("R8 after stray writes");
    rd("R8 unmapped read", 8'h04, 32'h0);
    rd("R8 unmapped read", 8'h40, 32'h0);
    rd_all("R8 regs intact");

    // R9: strobe low
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h28; reg_wdata = 32'h0;
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk_out("R9 no strobe");
    rd_all("R9 regs intact");

    // R6, R7: watchdog clock in deep sleep
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R6 ctl read", 8'h00, 32'h0004_0000);
    set_mode(2'd1);
    chk("R6 sleep keeps wdt", 32'(wdt_fclk_en), 32'd1);
    set_mode(2'd2);
    chk("R6 deep stops wdt", 32'(wdt_fclk_en), 32'd0);
    set_mode(2'd0);
    chk("R7 exit restores wdt", 32'(wdt_fclk_en), 32'd1);
    rd("R7 ctl kept", 8'h00, 32'h0004_0000);
    set_mode(2'd2);
    chk("R7 re-entry stops wdt", 32'(wdt_fclk_en), 32'd0);
    set_mode(2'd3);
    chk("R7 spare code restores wdt", 32'(wdt_fclk_en), 32'd1);
    wr(8'h00, 32'hFFFB_FFFF);
    set_mode(2'd2);
    chk("R6 bit clear keeps wdt", 32'(wdt_fclk_en), 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule